// File: doc/BRIEF.md
# Multithreaded Instruction Issue Scheduler

This block picks, in each clock cycle, at most one hardware thread to send its next instruction into a single-issue, in-order pipeline. It keeps a wait state for every thread. Stall inputs set that state: a data-cache load miss, a full store buffer, a pending long-latency result and an instruction-cache miss. A thread whose waits have all cleared can be picked again. Threads are chosen in rotation, so the latency of one thread is covered by the work of the others. The pipeline gets an empty slot only when every thread is blocked.

The block does not contain the caches, the decoder or the execution units. Miss sources give one-cycle set pulses and matching fill-done pulses. The store buffer gives a level per thread. The pipeline raises `long_op_i` when the instruction issuing in the current cycle is a long-latency one. Each thread shows a 2-bit code for a performance trace.

Top module: `issue_sched`

## Requirements
- R1: At most one thread issues per cycle, and `issue_tid_o` always names a thread whose state code is 0 (ready).
- R2: A pulse on `dmiss_set_i[t]` puts thread t in data wait (code 1) from the next cycle until the cycle after a `dfill_done_i[t]` pulse. A high `sbuf_full_i[t]` gives code 1 in the same cycle.
- R3: If a thread issues while `long_op_i` is high, it shows code 2 for the next 4 cycles and is ready in the 5th.
- R4: A pulse on `imiss_set_i[t]` puts thread t in instruction-cache wait (code 3) from the next cycle until the cycle after an `ifill_done_i[t]` pulse.
- R5: When several causes are active at once, data wait wins over long-latency wait, and long-latency wait wins over instruction-cache wait.
- R6: If a miss set pulse and its fill-done pulse reach the same thread in the same cycle, the wait stays set.
- R7: If every thread is blocked, `issue_valid_o` is 0 and `issue_tid_o` is 0.
- R8: The search for a thread to issue starts at the thread after the last one that issued, and wraps around. If any thread is ready, one issues.
- R9: After reset every thread shows code 0 and the search starts at thread 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dmiss_set_i | input | NUM_THR | Per-thread pulse: a data-cache load miss starts |
| dfill_done_i | input | NUM_THR | Per-thread pulse: the data fill completes |
| sbuf_full_i | input | NUM_THR | Per-thread level: the store buffer is full |
| imiss_set_i | input | NUM_THR | Per-thread pulse: an instruction-cache miss starts |
| ifill_done_i | input | NUM_THR | Per-thread pulse: the instruction fill completes |
| long_op_i | input | 1 | The instruction issuing this cycle has long latency |
| issue_valid_o | output | 1 | An instruction issues this cycle |
| issue_tid_o | output | TID_W | ID of the issuing thread |
| thr_state_o | output | 2*NUM_THR | State codes, thread t in bits [2t+1:2t] |

## Verification
Two kinds of events can land in the same cycle. The first is a set pulse and a fill-done pulse for the same thread. The bench drives both together and expects data wait in the following cycle. The second is a thread that issues a long-latency instruction while its instruction-cache miss is raised in that same cycle. The bench expects code 2 during the countdown, code 3 after the countdown ends, and the round-robin search skipping that thread the whole time.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    WS_READY  = 2'd0,
    WS_DATA   = 2'd1,
    WS_LONG   = 2'd2,
    WS_IFETCH = 2'd3
  } wait_code_e;
endpackage

// File: rtl/thr_wait_track.sv
module thr_wait_track
  import sched_pkg::*;
#(
  parameter int LAT_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dmiss_set_i,
  input  logic       dfill_done_i,
  input  logic       sbuf_full_i,
  input  logic       imiss_set_i,
  input  logic       ifill_done_i,
  input  logic       long_start_i,
  output logic       ready_o,
  output wait_code_e code_o
);
  localparam int CNT_W = $clog2(LAT_CYCLES + 1);

  logic             dmiss_q, imiss_q;
  logic [CNT_W-1:0] lat_cnt_q;

  // set wins over a fill in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dmiss_q   <= 1'b0;
      imiss_q   <= 1'b0;
      lat_cnt_q <= '0;
    end else begin
      dmiss_q <= dmiss_set_i | (dmiss_q & ~dfill_done_i);
      imiss_q <= imiss_set_i | (imiss_q & ~ifill_done_i);
      if (long_start_i)         lat_cnt_q <= CNT_W'(LAT_CYCLES);
      else if (lat_cnt_q != '0) lat_cnt_q <= lat_cnt_q - 1'b1;
    end
  end

  always_comb begin
    if (dmiss_q || sbuf_full_i) code_o = WS_DATA;
    else if (lat_cnt_q != '0)   code_o = WS_LONG;
    else if (imiss_q)           code_o = WS_IFETCH;
    else                        code_o = WS_READY;
  end

  assign ready_o = (code_o == WS_READY);
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int NUM_THR = 4,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic [NUM_THR-1:0] ready_i,
  input  logic [TID_W-1:0]   ptr_i,
  output logic               valid_o,
  output logic [TID_W-1:0]   tid_o
);
  always_comb begin
    int idx;
    valid_o = 1'b0;
    tid_o   = '0;
    for (int off = 0; off < NUM_THR; off++) begin
      idx = (int'(ptr_i) + off) % NUM_THR;
      if (!valid_o && ready_i[idx]) begin
        valid_o = 1'b1;
        tid_o   = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/issue_sched.sv
module issue_sched
  import sched_pkg::*;
#(
  parameter int NUM_THR    = 4,
  parameter int LAT_CYCLES = 4,
  localparam int TID_W     = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_THR-1:0]   dmiss_set_i,
  input  logic [NUM_THR-1:0]   dfill_done_i,
  input  logic [NUM_THR-1:0]   sbuf_full_i,
  input  logic [NUM_THR-1:0]   imiss_set_i,
  input  logic [NUM_THR-1:0]   ifill_done_i,
  input  logic                 long_op_i,
  output logic                 issue_valid_o,
  output logic [TID_W-1:0]     issue_tid_o,
  output logic [2*NUM_THR-1:0] thr_state_o
);
  logic [NUM_THR-1:0] ready;
  logic [TID_W-1:0]   rr_ptr_q;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    wait_code_e code;
    thr_wait_track #(.LAT_CYCLES(LAT_CYCLES)) u_trk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .dmiss_set_i (dmiss_set_i[t]),
      .dfill_done_i(dfill_done_i[t]),
      .sbuf_full_i (sbuf_full_i[t]),
      .imiss_set_i (imiss_set_i[t]),
      .ifill_done_i(ifill_done_i[t]),
      .long_start_i(issue_valid_o && long_op_i && (issue_tid_o == TID_W'(t))),
      .ready_o     (ready[t]),
      .code_o      (code)
    );
    assign thr_state_o[2*t +: 2] = code;
  end

  rr_pick #(.NUM_THR(NUM_THR)) u_pick (
    .ready_i(ready),
    .ptr_i  (rr_ptr_q),
    .valid_o(issue_valid_o),
    .tid_o  (issue_tid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rr_ptr_q <= '0;
    else if (issue_valid_o) rr_ptr_q <= TID_W'((int'(issue_tid_o) + 1) % NUM_THR);
  end
endmodule

// File: rtl/issue_sched_chk.sv
module issue_sched_chk #(
  parameter int NUM_THR    = 4,
  localparam int TID_W     = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_THR-1:0]   dmiss_set_i,
  input logic [NUM_THR-1:0]   imiss_set_i,
  input logic                 long_op_i,
  input logic                 issue_valid_o,
  input logic [TID_W-1:0]     issue_tid_o,
  input logic [2*NUM_THR-1:0] thr_state_o
);
  logic all_blk, any_rdy;
  always_comb begin
    all_blk = 1'b1;
    any_rdy = 1'b0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (thr_state_o[2*t +: 2] == 2'd0) begin
        all_blk = 1'b0;
        any_rdy = 1'b1;
      end
    end
  end

  a_r1_issue_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> thr_state_o[2*issue_tid_o +: 2] == 2'd0);

  a_r7_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_blk |-> !issue_valid_o);

  a_r8_work_conserving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rdy |-> issue_valid_o);

  a_r3_long_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && long_op_i) |=> !(issue_valid_o && issue_tid_o == $past(issue_tid_o)));

  for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
    a_r2_dmiss_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dmiss_set_i[t] |=> thr_state_o[2*t +: 2] == 2'd1);
    a_r4_imiss_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      imiss_set_i[t] |=> thr_state_o[2*t +: 2] != 2'd0);
  end
endmodule

bind issue_sched issue_sched_chk #(.NUM_THR(NUM_THR)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dmiss_set_i  (dmiss_set_i),
  .imiss_set_i  (imiss_set_i),
  .long_op_i    (long_op_i),
  .issue_valid_o(issue_valid_o),
  .issue_tid_o  (issue_tid_o),
  .thr_state_o  (thr_state_o)
);

// File: tb/issue_sched_bench.sv
`timescale 1ns/1ps
module issue_sched_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] dmiss_set_i = '0, dfill_done_i = '0, sbuf_full_i = '0;
  logic [3:0] imiss_set_i = '0, ifill_done_i = '0;
  logic       long_op_i = 1'b0;
  logic       issue_valid_o;
  logic [1:0] issue_tid_o;
  logic [7:0] thr_state_o;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [10:0] qd[$];
  string       qt[$];

  always #2.5 clk_i = ~clk_i;

  issue_sched u_issue_sched (.*);

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input logic [3:0] ds, input logic [3:0] df, input logic [3:0] sb,
                      input logic [3:0] is, input logic [3:0] ifd, input logic lop,
                      input logic ev, input logic [1:0] et, input logic [7:0] es,
                      input string tag);
    @(negedge clk_i);
    dmiss_set_i = ds; dfill_done_i = df; sbuf_full_i = sb;
    imiss_set_i = is; ifill_done_i = ifd; long_op_i = lop;
    qd.push_back({ev, et, es});
    qt.push_back(tag);
  endtask

  // monitor: compare away from the clock edge
  initial forever begin
    logic [10:0] d;
    string t;
    @(negedge clk_i);
    #1;
    if (qd.size() > 0) begin
      d = qd.pop_front();
      t = qt.pop_front();
      vectors++;
      if (issue_valid_o !== d[10] || (d[10] && issue_tid_o !== d[9:8]) ||
          (!d[10] && issue_tid_o !== 2'd0) || thr_state_o !== d[7:0]) begin
        errors++;
        $display("FAIL %s: got v=%0b tid=%0d st=%h, exp v=%0b tid=%0d st=%h",
                 t, issue_valid_o, issue_tid_o, thr_state_o, d[10], d[9:8], d[7:0]);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    step(0,0,0,0,0,0, 1,0,8'h00, "R9 reset state");
    @(posedge clk_i); #1 rst_ni = 1'b1;
    step(0,0,0,0,0,0, 1,0,8'h00, "R9 start at thread 0");
    step(0,0,0,0,0,0, 1,1,8'h00, "R8 rotate");
    step(0,0,0,0,0,0, 1,2,8'h00, "R8 rotate");
    step(0,0,0,0,0,0, 1,3,8'h00, "R8 rotate");
    step(0,0,0,0,0,0, 1,0,8'h00, "R8 wrap");
    step(4'b0010,0,0,0,0,0, 1,1,8'h00, "R2 set not yet visible");
    step(0,0,0,0,0,0, 1,2,8'h04, "R2 data wait");
    step(0,0,0,4'b1000,0,0, 1,3,8'h04, "R4 set not yet visible");
    step(0,0,0,0,0,1, 1,0,8'hC4, "R4 ifetch wait");
    step(0,0,0,0,0,0, 1,2,8'hC6, "R3 long wait 1");
    step(0,0,4'b0100,0,0,0, 0,0,8'hD6, "R7 all blocked, R2 sbuf");
    step(0,4'b0010,0,0,0,0, 1,2,8'hC6, "R3 long wait 3");
    step(0,0,0,0,0,0, 1,1,8'hC2, "R2 cleared, R3 wait 4");
    step(4'b0001,4'b0001,0,0,0,0, 1,2,8'hC0, "R3 ready 5th");
    step(0,0,0,4'b0001,0,0, 1,1,8'hC1, "R6 set wins");
    step(0,4'b0001,0,0,0,0, 1,2,8'hC1, "R5 data over ifetch");
    step(0,0,0,0,4'b1001,0, 1,1,8'hC3, "R4 ifetch after data clear");
    step(0,0,0,4'b0100,0,1, 1,2,8'h00, "R4 fills done");
    step(0,0,0,0,0,0, 1,3,8'h20, "R5 long over ifetch");
    step(0,0,0,0,0,0, 1,0,8'h20, "R5 long over ifetch");
    step(0,0,0,0,0,0, 1,1,8'h20, "R8 skip blocked");
    step(0,0,0,0,0,0, 1,3,8'h20, "R8 skip blocked");
    step(0,0,0,0,4'b0100,0, 1,0,8'h30, "R4 ifetch after countdown");
    step(0,0,0,0,0,0, 1,1,8'h00, "R1 all ready again");
    @(negedge clk_i);
    @(negedge clk_i);
    #2;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule